// File: doc/BRIEF.md
# Register Selector and Port-Enable Decoder

This block sits beside the instruction register of a three-bus datapath. It works out which general-purpose registers the instruction names for each bus. Two buses are read ports that feed operands into the datapath (read port 1 and read port 2). The third bus is a write port that returns a result into the register file. The block is purely combinational. It takes the 32-bit instruction word and produces three 3-bit register selectors, one per bus. It also produces three enables that tell the register file which of those ports the instruction actually uses.

The write selector and the read-port-2 selector always come from fixed bit fields. The read-port-1 selector has one exception. For the store-register instruction, the word held at bits 25..23 is a data source rather than a destination, so the block routes that field to read port 1. Every other instruction routes bits 19..17 to read port 1. A selector whose port enable is low carries a value that has no meaning, and the register file must ignore it.

The enables are decoded from the opcode class. The opcode is bits 31..27, and bit 26 is the indirection flag. An opcode outside the defined set drives all three enables low and raises an illegal-opcode flag. The control sequencer can use that flag to trap.

Top module: `reg_sel_decode`

## Requirements
- R1: `wr_sel_o` equals instruction bits 25..23 for every opcode.
- R2: `rd2_sel_o` equals instruction bits 22..20 for every opcode.
- R3: When the opcode (bits 31..27) is 01101 (store register), `rd1_sel_o` equals bits 25..23.
- R4: For every opcode other than 01101, `rd1_sel_o` equals bits 19..17.
- R5: Opcode 00000 (halt) drives all three enables low and `bad_op_o` low.
- R6: Opcodes 00001 (load immediate) and 01000 (input) drive only `wr_en_o` high.
- R7: Opcodes 00010 (AND immediate), 00011 (ADD immediate) and 01100 (load register) drive `rd2_en_o` and `wr_en_o` high and `rd1_en_o` low.
- R8: Opcodes 01001 (output), 01110 (subroutine call) and 01111 (branch) drive only `rd2_en_o` high.
- R9: Opcode 01101 (store register) drives `rd1_en_o` and `rd2_en_o` high and `wr_en_o` low.
- R10: Opcodes 10000 through 10100 (shifts and NOT) drive `rd2_en_o` and `wr_en_o` high and `rd1_en_o` low.
- R11: Opcodes 10101 through 11001 (two-operand ALU operations) drive all three enables high.
- R12: Every other opcode (00100-00111, 01010, 01011, 11010-11111) drives all enables low and `bad_op_o` high. `bad_op_o` is low for every listed opcode.
- R13: Bit 26 (the indirection flag) and bits 16..0 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word from the instruction register |
| rd1_sel_o | output | 3 | Register selector for read port 1 |
| rd2_sel_o | output | 3 | Register selector for read port 2 |
| wr_sel_o | output | 3 | Register selector for the write port |
| rd1_en_o | output | 1 | Instruction reads a register onto read port 1 |
| rd2_en_o | output | 1 | Instruction reads a register onto read port 2 |
| wr_en_o | output | 1 | Instruction writes a register from the write port |
| bad_op_o | output | 1 | Opcode is not in the defined set |

## Verification
The checker evaluates its properties whenever the instruction word is fully known. Before that, the word has no defined meaning, so its properties hold only for a word free of X or Z bits. The bench keeps within this limit: it drives a defined word, starting with all zeros, before the first comparison. It then walks every one of the 32 opcodes, with both values of the indirection flag and several distinct register-field patterns. The fields at bits 25..23 and 19..17 always differ, so a wrongly routed read-port-1 selector shows up in the output.

// File: rtl/regsel_pkg.sv
package regsel_pkg;
  localparam int OPC_W = 5;

  localparam logic [OPC_W-1:0] OPC_HALT  = 5'b00000;
  localparam logic [OPC_W-1:0] OPC_LDI   = 5'b00001;
  localparam logic [OPC_W-1:0] OPC_ANDI  = 5'b00010;
  localparam logic [OPC_W-1:0] OPC_ADDI  = 5'b00011;
  localparam logic [OPC_W-1:0] OPC_IN    = 5'b01000;
  localparam logic [OPC_W-1:0] OPC_OUT   = 5'b01001;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 5'b01100;
  localparam logic [OPC_W-1:0] OPC_STORE = 5'b01101;
  localparam logic [OPC_W-1:0] OPC_CALL  = 5'b01110;
  localparam logic [OPC_W-1:0] OPC_BRA   = 5'b01111;
  localparam logic [OPC_W-1:0] OPC_UNA_LO = 5'b10000;
  localparam logic [OPC_W-1:0] OPC_UNA_HI = 5'b10100;
  localparam logic [OPC_W-1:0] OPC_BIN_LO = 5'b10101;
  localparam logic [OPC_W-1:0] OPC_BIN_HI = 5'b11001;

  typedef struct packed {
    logic rd1;
    logic rd2;
    logic wr;
    logic bad;
  } port_use_t;
endpackage

// File: rtl/regsel_class_dec.sv
module regsel_class_dec
  import regsel_pkg::*;
(
  input  logic [OPC_W-1:0] opc_i,
  output port_use_t        use_o,
  output logic             store_o
);
  always_comb begin
    use_o = '0;
    unique case (opc_i)
      OPC_HALT:                      use_o = '0;
      OPC_LDI, OPC_IN:               use_o.wr  = 1'b1;
      OPC_ANDI, OPC_ADDI, OPC_LOAD: begin
        use_o.rd2 = 1'b1;
        use_o.wr  = 1'b1;
      end
      OPC_OUT, OPC_CALL, OPC_BRA:    use_o.rd2 = 1'b1;
      OPC_STORE: begin
        use_o.rd1 = 1'b1;
        use_o.rd2 = 1'b1;
      end
      default: begin
        if (opc_i >= OPC_UNA_LO && opc_i <= OPC_UNA_HI) begin
          use_o.rd2 = 1'b1;
          use_o.wr  = 1'b1;
        end else if (opc_i >= OPC_BIN_LO && opc_i <= OPC_BIN_HI) begin
          use_o.rd1 = 1'b1;
          use_o.rd2 = 1'b1;
          use_o.wr  = 1'b1;
        end else begin
          use_o.bad = 1'b1;
        end
      end
    endcase
  end

  assign store_o = (opc_i == OPC_STORE);
endmodule

// File: rtl/regsel_field_mux.sv
module regsel_field_mux #(
  parameter int SEL_W = 3
) (
  input  logic             store_i,
  input  logic [SEL_W-1:0] upper_i,
  input  logic [SEL_W-1:0] lower_i,
  output logic [SEL_W-1:0] sel_o
);
  assign sel_o = store_i ? upper_i : lower_i;
endmodule

// File: rtl/reg_sel_decode.sv
module reg_sel_decode
  import regsel_pkg::*;
#(
  parameter int INSTR_W = 32,
  parameter int SEL_W   = 3
) (
  input  logic [INSTR_W-1:0] instr_i,
  output logic [SEL_W-1:0]   rd1_sel_o,
  output logic [SEL_W-1:0]   rd2_sel_o,
  output logic [SEL_W-1:0]   wr_sel_o,
  output logic               rd1_en_o,
  output logic               rd2_en_o,
  output logic               wr_en_o,
  output logic               bad_op_o
);
  localparam int OPC_LSB  = INSTR_W - OPC_W;
  localparam int IBIT     = OPC_LSB - 1;
  localparam int NFIELD   = 3;
  localparam int FLD0_LSB = IBIT - SEL_W;
  localparam int LOW_W    = FLD0_LSB - (NFIELD - 1) * SEL_W;

  logic [SEL_W-1:0] fld [NFIELD];
  port_use_t        use_w;
  logic             store_w;
  logic             unused_bits;

  for (genvar k = 0; k < NFIELD; k++) begin : g_tap
    assign fld[k] = instr_i[FLD0_LSB - k*SEL_W +: SEL_W];
  end

  assign unused_bits = ^{instr_i[IBIT], instr_i[LOW_W-1:0]};

  regsel_class_dec u_class (
    .opc_i   (instr_i[INSTR_W-1 -: OPC_W]),
    .use_o   (use_w),
    .store_o (store_w)
  );

  regsel_field_mux #(.SEL_W(SEL_W)) u_rd1_mux (
    .store_i (store_w),
    .upper_i (fld[0]),
    .lower_i (fld[2]),
    .sel_o   (rd1_sel_o)
  );

  assign wr_sel_o  = fld[0];
  assign rd2_sel_o = fld[1];
  assign rd1_en_o  = use_w.rd1;
  assign rd2_en_o  = use_w.rd2;
  assign wr_en_o   = use_w.wr;
  assign bad_op_o  = use_w.bad;
endmodule

// File: rtl/reg_sel_decode_chk.sv
module reg_sel_decode_chk (
  input logic [31:0] instr_i,
  input logic [2:0]  rd1_sel_o,
  input logic [2:0]  wr_sel_o,
  input logic        rd1_en_o,
  input logic        rd2_en_o,
  input logic        wr_en_o,
  input logic        bad_op_o
);
  logic [4:0] op;
  assign op = instr_i[31:27];

  always_comb begin
    if (!$isunknown(instr_i)) begin
      assert_store_upper_R3: assert (op != 5'b01101 || rd1_sel_o == instr_i[25:23]);
      assert_other_lower_R4: assert (op == 5'b01101 || rd1_sel_o == instr_i[19:17]);
      assert_halt_idle_R5:   assert (op != 5'b00000 || {rd1_en_o, rd2_en_o, wr_en_o, bad_op_o} == 4'b0000);
      assert_store_nowr_R9:  assert (!(rd1_en_o && !wr_en_o) || op == 5'b01101);
      assert_illegal_R12:    assert (!bad_op_o || {rd1_en_o, rd2_en_o, wr_en_o} == 3'b000);
      assert_rd1_needs_rd2_R11: assert (!rd1_en_o || rd2_en_o);
      assert_sel_match_R1:   assert (wr_sel_o == instr_i[25:23]);
    end
  end
endmodule

bind reg_sel_decode reg_sel_decode_chk u_chk (
  .instr_i   (instr_i),
  .rd1_sel_o (rd1_sel_o),
  .wr_sel_o  (wr_sel_o),
  .rd1_en_o  (rd1_en_o),
  .rd2_en_o  (rd2_en_o),
  .wr_en_o   (wr_en_o),
  .bad_op_o  (bad_op_o)
);

// File: tb/test_reg_sel_decode.sv
module test_reg_sel_decode;
  typedef struct {
    logic [2:0] rd1, rd2, wr;
    logic [3:0] en;
    string      cls;
    string      r1tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] instr_i = '0;
  logic [2:0]  rd1_sel_o, rd2_sel_o, wr_sel_o;
  logic        rd1_en_o, rd2_en_o, wr_en_o, bad_op_o;
  int          n_run = 0;
  int          n_fail = 0;
  int          cycles = 0;
  exp_t        q[$];

  always #5 clk = ~clk;

  reg_sel_decode i_reg_sel_decode (
    .instr_i   (instr_i),
    .rd1_sel_o (rd1_sel_o),
    .rd2_sel_o (rd2_sel_o),
    .wr_sel_o  (wr_sel_o),
    .rd1_en_o  (rd1_en_o),
    .rd2_en_o  (rd2_en_o),
    .wr_en_o   (wr_en_o),
    .bad_op_o  (bad_op_o)
  );

  // expected enables {rd1, rd2, wr, bad} and class tag, from the requirement list
  function automatic void class_of(input logic [4:0] op, output logic [3:0] en, output string tag);
    case (op)
      5'd0:           begin en = 4'b0000; tag = "R5";  end
      5'd1, 5'd8:     begin en = 4'b0010; tag = "R6";  end
      5'd2, 5'd3, 5'd12: begin en = 4'b0110; tag = "R7"; end
      5'd9, 5'd14, 5'd15: begin en = 4'b0100; tag = "R8"; end
      5'd13:          begin en = 4'b1100; tag = "R9";  end
      5'd16, 5'd17, 5'd18, 5'd19, 5'd20: begin en = 4'b0110; tag = "R10"; end
      5'd21, 5'd22, 5'd23, 5'd24, 5'd25: begin en = 4'b1110; tag = "R11"; end
      default:        begin en = 4'b0001; tag = "R12"; end
    endcase
  endfunction

  task automatic drive(input logic [4:0] op, input logic ib, input logic [2:0] a,
                       input logic [2:0] b, input logic [2:0] c, input logic [16:0] low);
    exp_t e;
    @(posedge clk);
    instr_i = {op, ib, a, b, c, low};
    e.wr  = a;
    e.rd2 = b;
    e.rd1 = (op == 5'b01101) ? a : c;
    e.r1tag = (op == 5'b01101) ? "R3" : "R4";
    class_of(op, e.en, e.cls);
    if (ib || low != 17'h0) e.cls = {e.cls, " R13"};
    q.push_back(e);
  endtask

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s instr=%h actual=%h expected=%h", tag, instr_i, act, exp);
    end
  endtask

  // monitor: compares away from the driving edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      logic [3:0] got;
      e = q.pop_front();
      got = {rd1_en_o, rd2_en_o, wr_en_o, bad_op_o};
      check(wr_sel_o == e.wr, "R1", 32'(wr_sel_o), 32'(e.wr));
      check(rd2_sel_o == e.rd2, "R2", 32'(rd2_sel_o), 32'(e.rd2));
      check(rd1_sel_o == e.rd1, e.r1tag, 32'(rd1_sel_o), 32'(e.rd1));
      check(got == e.en, e.cls, 32'(got), 32'(e.en));
    end
  end

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    rst = 1'b0;
    // reset-state word: all zeros is halt (R5)
    drive(5'd0, 1'b0, 3'd0, 3'd0, 3'd0, 17'h0);
    for (int op = 0; op < 32; op++) begin
      drive(5'(op), 1'b0, 3'd1, 3'd2, 3'd3, 17'h0);
      drive(5'(op), 1'b1, 3'd7, 3'd0, 3'd5, 17'h1A5A5);
      drive(5'(op), 1'b0, 3'd4, 3'd6, 3'd1, 17'h1FFFF);
      drive(5'(op), 1'b1, 3'd2, 3'd5, 3'd6, 17'h00001);
    end
    // store versus dyadic with the same fields: R3 against R4
    drive(5'b01101, 1'b0, 3'd6, 3'd3, 3'd1, 17'h0);
    drive(5'b10101, 1'b0, 3'd6, 3'd3, 3'd1, 17'h0);
    while (q.size() > 0) @(posedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule